// File: doc/BRIEF.md
# Pulse-Count Trigger Command Codec

This block carries the trigger and control channel of a point-to-point link between a readout concentrator and one front-end card. On the concentrator side, an encoder takes a two-bit command request and plays it out as a burst of single-cycle pulses on one trigger wire. The number of pulses in the burst identifies the command. On the card side, a decoder counts the pulses. When a burst has ended, it raises a one-cycle strobe for the command it recognised, or a one-cycle decode-error flag when the count matches no command.

The card also drives a return line back toward the concentrator. The line rests high to report Ready. While the card's error input is asserted, it repeats a low-low-high-high pattern. Both sides run from the link clock. The concentrator may switch a card off by halting that clock, so all state freezes cleanly and carries on when the clock returns. The top module holds both ends of the link, so the trigger output can be looped back to the trigger input or driven separately.

Top module: `trig_link_codec`

## Requirements
- R1: For command code c (0 to 3) the encoder emits exactly 2*(c+1) pulses on `trig_out`: code 0 gives 2 pulses (level-0 trigger), code 1 gives 4 (level-1 trigger), code 2 gives 6 (level-2/readout), code 3 gives 8 (control). Each pulse is high for one cycle, and consecutive pulses are separated by exactly one low cycle.
- R2: A request is taken only at a clock edge where `req_valid` is high and `enc_busy` is low. `enc_busy` is high from the cycle after acceptance until the burst and its trailing gap are complete. A request presented while busy is ignored and produces no later burst.
- R3: After the last pulse of a burst, `trig_out` stays low for at least 4 cycles before `enc_busy` falls.
- R4: When the decoder has seen 2, 4, 6 or 8 pulses on `trig_in`, followed by 4 consecutive low cycles, it sets bit c of `cmd_stb` (c = count/2 - 1) for exactly one cycle. That cycle is the one right after the edge that samples the fourth low. No strobe appears before that point.
- R5: Any other burst length (odd counts, or more than 8) raises `dec_err` for one cycle at the same point and leaves `cmd_stb` at zero.
- R6: Pulses separated by fewer than 4 consecutive low cycles count as one burst.
- R7: `ret_out` is high in every cycle that follows an edge at which `err_in` was sampled low.
- R8: While `err_in` is sampled high, `ret_out` repeats low, low, high, high, starting in the cycle after the first high sample.
- R9: Halting the link clock at any point, including partway through a burst, and then restarting it leaves the burst, its decoding and the strobe timing in clock cycles unchanged.
- R10: Synchronous reset (`rst` high at a clock edge) forces `trig_out` low, `enc_busy` low, `cmd_stb` and `dec_err` to zero and `ret_out` high. It also discards any partly counted burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock, may be halted |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Command request |
| req_cmd | input | 2 | Command code of the request |
| enc_busy | output | 1 | Encoder is sending a burst or gap |
| trig_out | output | 1 | Encoded trigger line toward the card |
| trig_in | input | 1 | Trigger line as received by the card |
| cmd_stb | output | 4 | One-cycle strobe, bit index = command code |
| dec_err | output | 1 | One-cycle flag for an unrecognised burst |
| err_in | input | 1 | Card error condition |
| ret_out | output | 1 | Coded status line toward the concentrator |

## Verification
The bench drives bursts of every length from 1 to 12 straight into the decoder. It checks the strobe in the exact cycle after the fourth low, so a decoder that evaluated the count one cycle early or late, or that accepted odd counts, would be caught. Inter-pulse gaps of two and three low cycles test a decoder that closed a burst too soon: it would split a level-1 command into two level-0 strobes. Looped-back encoder runs, some with a request arriving mid-burst and some with the clock halted mid-burst, expose an encoder that accepts while busy or loses a pulse across a clock stop. Resets applied in the middle of bursts expose leftover counts that would merge with the next burst. The return-line checks compare the exact low/high phase against the error input.

// File: rtl/trig_link_pkg.sv
package trig_link_pkg;
    localparam int NUM_CMD    = 4;
    localparam int CODE_W     = $clog2(NUM_CMD);
    localparam int MAX_PULSES = 2 * NUM_CMD;

    typedef enum logic [1:0] {
        ENC_IDLE,
        ENC_HIGH,
        ENC_LOW,
        ENC_GAP
    } enc_state_e;

    // Pulse count assigned to a command code
    function automatic int unsigned pulses_for(input int unsigned code);
        return 2 * (code + 1);
    endfunction
endpackage

// File: rtl/trig_burst_enc.sv
module trig_burst_enc
    import trig_link_pkg::*;
#(
    parameter int GAP_LOW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [CODE_W-1:0] req_cmd,
    output logic              busy,
    output logic              trig
);
    localparam int LEFT_W = $clog2(MAX_PULSES);
    localparam int GAP_W  = (GAP_LOW > 1) ? $clog2(GAP_LOW) : 1;

    typedef struct packed {
        enc_state_e        state;
        logic [LEFT_W-1:0] left;
        logic [GAP_W-1:0]  gap;
        logic              trig;
    } enc_t;

    enc_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.trig = 1'b0;
        case (st_q.state)
            ENC_IDLE: begin
                if (req_valid) begin
                    st_d.state = ENC_HIGH;
                    st_d.trig  = 1'b1;
                    st_d.left  = LEFT_W'(pulses_for(32'(req_cmd)) - 1);
                end
            end
            ENC_HIGH: begin
                if (st_q.left == '0) begin
                    st_d.state = ENC_GAP;
                    st_d.gap   = GAP_W'(GAP_LOW - 1);
                end else begin
                    st_d.state = ENC_LOW;
                end
            end
            ENC_LOW: begin
                st_d.state = ENC_HIGH;
                st_d.trig  = 1'b1;
                st_d.left  = st_q.left - 1'b1;
            end
            ENC_GAP: begin
                if (st_q.gap == '0) begin
                    st_d.state = ENC_IDLE;
                end else begin
                    st_d.gap = st_q.gap - 1'b1;
                end
            end
            default: st_d.state = ENC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{state: ENC_IDLE, left: '0, gap: '0, trig: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.state != ENC_IDLE);
    assign trig = st_q.trig;
endmodule

// File: rtl/trig_burst_dec.sv
module trig_burst_dec
    import trig_link_pkg::*;
#(
    parameter int END_LOW = 4,
    parameter int CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               trig,
    output logic [NUM_CMD-1:0] stb,
    output logic               err
);
    localparam int LOW_W = (END_LOW > 1) ? $clog2(END_LOW) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic [LOW_W-1:0]   low_run;
        logic [NUM_CMD-1:0] stb;
        logic               err;
    } dec_t;

    dec_t st_d, st_q;
    logic [NUM_CMD-1:0] match;

    for (genvar c = 0; c < NUM_CMD; c++) begin : g_match
        assign match[c] = (st_q.cnt == CNT_W'(pulses_for(c)));
    end

    always_comb begin
        st_d     = st_q;
        st_d.stb = '0;
        st_d.err = 1'b0;
        if (trig) begin
            st_d.low_run = '0;
            if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (st_q.cnt != '0) begin
            if (st_q.low_run == LOW_W'(END_LOW - 1)) begin
                st_d.stb     = match;
                st_d.err     = ~(|match);
                st_d.cnt     = '0;
                st_d.low_run = '0;
            end else begin
                st_d.low_run = st_q.low_run + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stb = st_q.stb;
    assign err = st_q.err;
endmodule

// File: rtl/trig_status_tx.sv
module trig_status_tx #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic fault,
    output logic line
);
    localparam int PH_W = $clog2(2 * HALF);

    typedef struct packed {
        logic [PH_W-1:0] ph;
        logic            line;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fault) begin
            st_d.line = (st_q.ph >= PH_W'(HALF));
            st_d.ph   = (st_q.ph == PH_W'(2 * HALF - 1)) ? '0 : st_q.ph + 1'b1;
        end else begin
            st_d.line = 1'b1;
            st_d.ph   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{ph: '0, line: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign line = st_q.line;
endmodule

// File: rtl/trig_link_codec.sv
module trig_link_codec
    import trig_link_pkg::*;
#(
    parameter int GAP_LOW = 4,
    parameter int CNT_W   = 4,
    parameter int ERR_HALF = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [CODE_W-1:0]  req_cmd,
    output logic               enc_busy,
    output logic               trig_out,
    input  logic               trig_in,
    output logic [NUM_CMD-1:0] cmd_stb,
    output logic               dec_err,
    input  logic               err_in,
    output logic               ret_out
);
    trig_burst_enc #(.GAP_LOW(GAP_LOW)) u_enc (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_cmd  (req_cmd),
        .busy     (enc_busy),
        .trig     (trig_out)
    );

    trig_burst_dec #(.END_LOW(GAP_LOW), .CNT_W(CNT_W)) u_dec (
        .clk (clk),
        .rst (rst),
        .trig(trig_in),
        .stb (cmd_stb),
        .err (dec_err)
    );

    trig_status_tx #(.HALF(ERR_HALF)) u_stat (
        .clk  (clk),
        .rst  (rst),
        .fault(err_in),
        .line (ret_out)
    );
endmodule

// File: rtl/trig_link_chk.sv
module trig_link_chk
    import trig_link_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               enc_busy,
    input logic               trig_out,
    input logic [NUM_CMD-1:0] cmd_stb,
    input logic               dec_err,
    input logic               err_in,
    input logic               ret_out
);
    p_single_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        trig_out |=> !trig_out);

    p_trig_in_burst_r2: assert property (@(posedge clk) disable iff (rst)
        trig_out |-> enc_busy);

    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !enc_busy) |=> enc_busy);

    p_tail_gap_r3: assert property (@(posedge clk) disable iff (rst)
        ($fell(enc_busy) && !$past(rst)) |->
        (!$past(trig_out) && !$past(trig_out, 2) && !$past(trig_out, 3) && !$past(trig_out, 4)));

    p_stb_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd_stb));

    p_stb_single_r4: assert property (@(posedge clk) disable iff (rst)
        (|cmd_stb) |=> (cmd_stb == '0));

    p_err_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
        dec_err |-> (cmd_stb == '0));

    p_ready_line_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(err_in) |-> ret_out);
endmodule

bind trig_link_codec trig_link_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .enc_busy (enc_busy),
    .trig_out (trig_out),
    .cmd_stb  (cmd_stb),
    .dec_err  (dec_err),
    .err_in   (err_in),
    .ret_out  (ret_out)
);

// File: tb/trig_link_codec_bench.sv
module trig_link_codec_bench;
    import trig_link_pkg::*;

    logic clk = 1'b0;
    logic clk_run = 1'b1;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [CODE_W-1:0] req_cmd = '0;
    logic enc_busy, trig_out, trig_in, dec_err, ret_out;
    logic [NUM_CMD-1:0] cmd_stb;
    logic err_in = 1'b0;
    logic use_enc = 1'b0;
    logic drv_trig = 1'b0;
    int checks = 0;
    int errors = 0;

    assign trig_in = use_enc ? trig_out : drv_trig;

    always begin
        #5;
        if (clk_run) clk = ~clk;
    end

    trig_link_codec u_trig_link_codec (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
        .enc_busy(enc_busy), .trig_out(trig_out), .trig_in(trig_in),
        .cmd_stb(cmd_stb), .dec_err(dec_err), .err_in(err_in), .ret_out(ret_out)
    );

    function automatic int code_of(input int n);
        if (n >= 2 && n <= 2 * NUM_CMD && (n % 2) == 0) return n / 2 - 1;
        return -1;
    endfunction

    function automatic int stb_exp(input int code);
        return (code < 0) ? 0 : (1 << code);
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic raw_burst(input int n, input int lg);
        bit early = 0;
        int code = code_of(n);
        use_enc = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); drv_trig = 1'b1;
            @(negedge clk); drv_trig = 1'b0;
            if (cmd_stb != 0 || dec_err) early = 1;
            if (i < n - 1) begin
                for (int k = 1; k < lg; k++) begin
                    @(negedge clk);
                    if (cmd_stb != 0 || dec_err) early = 1;
                end
            end
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (cmd_stb != 0 || dec_err) early = 1;
        end
        chk(!early, (lg > 1) ? "R6" : "R4", "no strobe before burst end", early, 0);
        @(negedge clk);
        chk(int'(cmd_stb) == stb_exp(code), "R4", "strobe after fourth low", cmd_stb, stb_exp(code));
        chk(dec_err == (code < 0), "R5", "decode error flag", dec_err, code < 0);
        @(negedge clk);
        chk(cmd_stb == 0 && !dec_err, "R4", "strobe lasts one cycle", cmd_stb, 0);
    endtask

    task automatic run_cmd(input int code, input bit spur, input bit pause);
        int highs = 0, tail = 0, cyc = 0;
        bit prev = 0, dbl = 0, early = 0;
        use_enc = 1'b1;
        @(negedge clk); req_valid = 1'b1; req_cmd = CODE_W'(code);
        @(negedge clk); req_valid = 1'b0;
        chk(enc_busy, "R2", "busy after accept", enc_busy, 1);
        while (enc_busy && cyc < 100) begin
            if (trig_out) begin
                if (prev) dbl = 1;
                highs++;
                tail = 0;
            end else begin
                tail++;
            end
            if (cmd_stb != 0 || dec_err) early = 1;
            prev = trig_out;
            if (spur && cyc == 3) begin
                req_valid = 1'b1;
                req_cmd = CODE_W'((code + 1) % NUM_CMD);
            end else begin
                req_valid = 1'b0;
            end
            if (pause && cyc == 5) begin
                clk_run = 1'b0;
                #137;
                clk_run = 1'b1;
            end
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        chk(highs == int'(pulses_for(code)), pause ? "R9" : "R1", "pulse count", highs, pulses_for(code));
        chk(!dbl, "R1", "one low between pulses", dbl, 0);
        chk(tail >= 4, "R3", "trailing low cycles", tail, 4);
        chk(!early, "R4", "no early strobe", early, 0);
        chk(int'(cmd_stb) == stb_exp(code) && !dec_err, pause ? "R9" : "R4",
            "loopback strobe", cmd_stb, stb_exp(code));
        begin
            bit extra = 0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (enc_busy || trig_out || (k > 0 && cmd_stb != 0)) extra = 1;
            end
            chk(!extra, "R2", "request during burst ignored", extra, 0);
        end
        use_enc = 1'b0;
    endtask

    initial begin
        #1_500_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(!trig_out && !enc_busy && cmd_stb == 0 && !dec_err && ret_out, "R10",
            "reset state", {trig_out, enc_busy, dec_err, ret_out}, 1);

        // Directed decoder counts 1..12
        for (int n = 1; n <= 12; n++) raw_burst(n, 1);
        // Short gaps stay in one burst
        raw_burst(4, 3);
        raw_burst(6, 2);

        // Encoder loopback, every code, with and without a mid-burst request
        for (int c = 0; c < NUM_CMD; c++) run_cmd(c, 1'b0, 1'b0);
        for (int c = 0; c < NUM_CMD; c++) run_cmd(c, 1'b1, 1'b0);
        // Clock halted mid-burst
        run_cmd(3, 1'b0, 1'b1);
        run_cmd(1, 1'b1, 1'b1);

        // Random mix
        for (int i = 0; i < 30; i++) begin
            if ($urandom % 2) run_cmd(int'($urandom % NUM_CMD), 1'($urandom % 2), 1'($urandom % 2));
            else raw_burst(int'($urandom % 11) + 1, int'($urandom % 3) + 1);
        end

        // Reset discards a partial count
        use_enc = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); drv_trig = 1'b1;
            @(negedge clk); drv_trig = 1'b0;
        end
        rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        raw_burst(2, 1);

        // Reset during an encoder burst
        use_enc = 1'b1;
        @(negedge clk); req_valid = 1'b1; req_cmd = 2'd3;
        @(negedge clk); req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk(!enc_busy && !trig_out && cmd_stb == 0, "R10", "reset mid-burst", {enc_busy, trig_out}, 0);
        begin
            bit extra = 0;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (enc_busy || trig_out || cmd_stb != 0 || dec_err) extra = 1;
            end
            chk(!extra, "R10", "quiet after reset", extra, 0);
        end
        use_enc = 1'b0;

        // Return line
        chk(ret_out, "R7", "ready level", ret_out, 1);
        @(negedge clk); err_in = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk(ret_out == ((k % 4) >= 2), "R8", "error pattern", ret_out, (k % 4) >= 2);
        end
        err_in = 1'b0;
        @(negedge clk);
        chk(ret_out, "R7", "ready after error cleared", ret_out, 1);
        repeat (5) @(negedge clk);
        chk(ret_out, "R7", "ready held", ret_out, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule